// File: doc/BRIEF.md
# Dual-Unit Conversion Result Compare Monitor

This block watches the stream of results coming out of an analog-to-digital converter and raises a flag when a chosen channel keeps producing values on one side of a programmed limit. It holds two compare units that work independently of each other. Each unit is set up with five things:

- an enable bit;
- the channel it listens to;
- a mode bit that selects either "result below the limit" or "result at or above the limit";
- a 12-bit limit;
- a 4-bit run-length threshold.

Each result arrives on a single-cycle valid strobe, together with its channel number and its 12-bit value. A unit ignores a result unless the result's channel matches the unit's channel. A matching result that meets the condition lengthens the unit's run of hits. A matching result that fails the condition ends the run.

When a run reaches the threshold plus one hits, the unit sets a sticky flag. The flag stays set until software writes a one to the unit's clear input. The interrupt output is the OR of the flags, each gated by its own interrupt-enable bit. Register decoding sits outside this block: the configuration arrives as plain input vectors, and the clear arrives as a one-cycle pulse per unit.

Top module: `adc_cmp_monitor`

## Requirements
- R1: The two units keep separate configuration, separate hit counters and separate flags. Activity in one unit never changes the state of the other.
- R2: A unit's counter and flag change only for a result that has `res_valid`=1 and a channel equal to the unit's channel. Results from other channels, and cycles with the strobe low, leave them as they are.
- R3: Mode bit 0 counts a hit when the result is unsigned-less-than the limit. Mode bit 1 counts a hit when the result is greater than or equal to the limit. A result equal to the limit is therefore a hit only in mode 1.
- R4: With threshold T, the flag is set at the clock edge that accepts the (T+1)th consecutive hit, and the flag output shows 1 from the cycle after that edge.
- R5: A result from the unit's channel that fails the condition resets that unit's hit counter to zero.
- R6: A 1 on a unit's bit of `flag_clr` clears that unit's flag and its counter at the next edge. If a result arrives in the same cycle, the clear takes priority and the result is dropped.
- R7: While a unit's enable bit is 0, it holds its counter at zero and never sets its flag. A flag that is already set keeps its value.
- R8: `irq` is the combinational OR, over both units, of each flag ANDed with that unit's bit of `cfg_irq_en`.
- R9: After reset both flags and `irq` are 0 and both counters are zero.
- R10: Once set, a flag stays set through later hits, failing results and disabling, until it is cleared as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_chan | input | 3 | Channel number of the result |
| res_data | input | 12 | Result value, unsigned |
| cfg_en | input | 2 | Enable bit of each unit (bit i = unit i) |
| cfg_chan | input | 6 | Channel to watch; unit i uses bits [3i+2:3i] |
| cfg_ge | input | 2 | Mode bit of each unit: 0 = less than, 1 = greater or equal |
| cfg_limit | input | 24 | 12-bit limit; unit i uses bits [12i+11:12i] |
| cfg_thresh | input | 8 | 4-bit run threshold; unit i uses bits [4i+3:4i] |
| cfg_irq_en | input | 2 | Interrupt enable of each unit |
| flag_clr | input | 2 | Write-one-to-clear pulse for each unit's flag |
| cmp_flag | output | 2 | Sticky compare flag of each unit |
| irq | output | 1 | Gated OR of the flags |

## Verification
The hardest situations to reach from the ports are a run of hits that is interrupted only by results from foreign channels, and a clear that lands in the same cycle as the hit that would complete a run. In both cases the expected flag depends on the exact count history. Directed sequences build each run to one short of its threshold, then insert foreign-channel results, strobe-low cycles, an equal-to-limit result, a clear or a disable at that point. A long randomized phase then confines channels to a small range around the watched ones, so that runs, resets and clears interleave often. A behavioural model checks every cycle.

// File: rtl/adc_cmp_pkg.sv
// Package: shared types for the compare monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_cmp_pkg;

    // Encoding of the per-unit mode bit
    typedef enum logic {
        CMP_BELOW   = 1'b0,
        CMP_AT_OVER = 1'b1
    } cmp_mode_e;

endpackage

// File: rtl/adc_cmp_match.sv
// Module: adc_cmp_match
// Decides, in one combinational step, whether the current result belongs to
// this unit (selected) and whether it meets the unit's condition (hit).
// Assumes: res_data and cfg_limit are unsigned.
module adc_cmp_match
    import adc_cmp_pkg::*;
#(
    parameter int CH_W  = 3,
    parameter int RES_W = 12
) (
    input  logic             res_valid,
    input  logic [CH_W-1:0]  res_chan,
    input  logic [RES_W-1:0] res_data,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             cfg_ge,
    input  logic [RES_W-1:0] cfg_limit,
    output logic             selected,
    output logic             hit
);

    cmp_mode_e mode;
    logic      below;

    // Channel filter and condition evaluation
    always_comb begin
        mode     = cmp_mode_e'(cfg_ge);
        below    = (res_data < cfg_limit);
        selected = res_valid && (res_chan == cfg_chan);
        hit      = (mode == CMP_BELOW) ? below : !below;
    end

endmodule

// File: rtl/adc_cmp_track.sv
// Module: adc_cmp_track
// Counts consecutive hits and sets a sticky flag once the run length exceeds
// the threshold. The counter saturates at the threshold once it is reached.
// Assumes: clr is a single-cycle write-one pulse; reset is synchronous, active low.
module adc_cmp_track #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             selected,
    input  logic             hit,
    input  logic [THR_W-1:0] thresh,
    output logic             flag
);

    logic [THR_W-1:0] run_cnt;
    logic             run_done;

    // Run has already reached the threshold count
    always_comb run_done = (run_cnt >= thresh);

    // Run counter and sticky flag update; clear beats everything else
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (clr) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (!en) begin
            run_cnt <= '0;
        end else if (selected) begin
            if (!hit) begin
                run_cnt <= '0;
            end else if (run_done) begin
                flag <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_cmp_unit.sv
// Module: adc_cmp_unit
// One compare unit: channel and condition match feeding a run tracker.
// Assumes: configuration inputs are stable while results are being counted.
module adc_cmp_unit #(
    parameter int CH_W  = 3,
    parameter int RES_W = 12,
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [CH_W-1:0]  res_chan,
    input  logic [RES_W-1:0] res_data,
    input  logic             cfg_en,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic             cfg_ge,
    input  logic [RES_W-1:0] cfg_limit,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic             flag_clr,
    output logic             flag
);

    logic selected;
    logic hit;

    adc_cmp_match #(.CH_W(CH_W), .RES_W(RES_W)) u_match (
        .res_valid (res_valid),
        .res_chan  (res_chan),
        .res_data  (res_data),
        .cfg_chan  (cfg_chan),
        .cfg_ge    (cfg_ge),
        .cfg_limit (cfg_limit),
        .selected  (selected),
        .hit       (hit)
    );

    adc_cmp_track #(.THR_W(THR_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .clr      (flag_clr),
        .selected (selected),
        .hit      (hit),
        .thresh   (cfg_thresh),
        .flag     (flag)
    );

endmodule

// File: rtl/adc_cmp_monitor.sv
// Module: adc_cmp_monitor (top)
// Holds NUM_UNITS independent compare units that watch the converter's result
// stream, plus the gated interrupt OR.
// Assumes: per-unit fields are packed with unit 0 in the least significant slice.
module adc_cmp_monitor #(
    parameter int NUM_UNITS = 2,
    parameter int CH_W      = 3,
    parameter int RES_W     = 12,
    parameter int THR_W     = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       res_valid,
    input  logic [CH_W-1:0]            res_chan,
    input  logic [RES_W-1:0]           res_data,
    input  logic [NUM_UNITS-1:0]       cfg_en,
    input  logic [NUM_UNITS*CH_W-1:0]  cfg_chan,
    input  logic [NUM_UNITS-1:0]       cfg_ge,
    input  logic [NUM_UNITS*RES_W-1:0] cfg_limit,
    input  logic [NUM_UNITS*THR_W-1:0] cfg_thresh,
    input  logic [NUM_UNITS-1:0]       cfg_irq_en,
    input  logic [NUM_UNITS-1:0]       flag_clr,
    output logic [NUM_UNITS-1:0]       cmp_flag,
    output logic                       irq
);

    // One unit per slice of the packed configuration
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        adc_cmp_unit #(.CH_W(CH_W), .RES_W(RES_W), .THR_W(THR_W)) u_unit (
            .clk        (clk),
            .rst_n      (rst_n),
            .res_valid  (res_valid),
            .res_chan   (res_chan),
            .res_data   (res_data),
            .cfg_en     (cfg_en[u]),
            .cfg_chan   (cfg_chan[u*CH_W +: CH_W]),
            .cfg_ge     (cfg_ge[u]),
            .cfg_limit  (cfg_limit[u*RES_W +: RES_W]),
            .cfg_thresh (cfg_thresh[u*THR_W +: THR_W]),
            .flag_clr   (flag_clr[u]),
            .flag       (cmp_flag[u])
        );
    end

    // Interrupt: OR of flags gated by their enables
    always_comb irq = |(cmp_flag & cfg_irq_en);

endmodule

// File: rtl/adc_cmp_checker.sv
// Module: adc_cmp_checker
// Temporal properties of the compare monitor, observed at its ports.
// Assumes: bound to adc_cmp_monitor with matching parameters.
module adc_cmp_checker #(
    parameter int NUM_UNITS = 2,
    parameter int CH_W      = 3,
    parameter int RES_W     = 12,
    parameter int THR_W     = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       res_valid,
    input logic [CH_W-1:0]            res_chan,
    input logic [RES_W-1:0]           res_data,
    input logic [NUM_UNITS-1:0]       cfg_en,
    input logic [NUM_UNITS*CH_W-1:0]  cfg_chan,
    input logic [NUM_UNITS-1:0]       cfg_ge,
    input logic [NUM_UNITS*RES_W-1:0] cfg_limit,
    input logic [NUM_UNITS*THR_W-1:0] cfg_thresh,
    input logic [NUM_UNITS-1:0]       flag_clr,
    input logic [NUM_UNITS-1:0]       cmp_flag,
    input logic                       irq
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        logic mine;
        logic cond_ok;

        // Observer-side view of this unit's selection and condition
        always_comb begin
            mine    = res_valid && (res_chan == cfg_chan[u*CH_W +: CH_W]);
            cond_ok = cfg_ge[u] ? (res_data >= cfg_limit[u*RES_W +: RES_W])
                                : (res_data <  cfg_limit[u*RES_W +: RES_W]);
        end

        a_r6_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
            flag_clr[u] |=> !cmp_flag[u]);

        a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_flag[u] && !flag_clr[u] |=> cmp_flag[u]);

        a_r7_disabled_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en[u] && !cmp_flag[u] |=> !cmp_flag[u]);

        a_r2_foreign_no_set: assert property (@(posedge clk) disable iff (!rst_n)
            !cmp_flag[u] && !mine |=> !cmp_flag[u]);

        a_r4_zero_thresh_sets: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_en[u] && !flag_clr[u] && mine && cond_ok &&
            (cfg_thresh[u*THR_W +: THR_W] == '0) |=> cmp_flag[u]);
    end

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmp_flag != '0));

endmodule

bind adc_cmp_monitor adc_cmp_checker #(
    .NUM_UNITS (NUM_UNITS),
    .CH_W      (CH_W),
    .RES_W     (RES_W),
    .THR_W     (THR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_chan   (res_chan),
    .res_data   (res_data),
    .cfg_en     (cfg_en),
    .cfg_chan   (cfg_chan),
    .cfg_ge     (cfg_ge),
    .cfg_limit  (cfg_limit),
    .cfg_thresh (cfg_thresh),
    .flag_clr   (flag_clr),
    .cmp_flag   (cmp_flag),
    .irq        (irq)
);

// File: tb/tb_adc_cmp_monitor.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module tb_adc_cmp_monitor;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_valid;
    logic [2:0]  res_chan;
    logic [11:0] res_data;
    logic [1:0]  cfg_en;
    logic [5:0]  cfg_chan;
    logic [1:0]  cfg_ge;
    logic [23:0] cfg_limit;
    logic [7:0]  cfg_thresh;
    logic [1:0]  cfg_irq_en;
    logic [1:0]  flag_clr;
    logic [1:0]  cmp_flag;
    logic        irq;

    int    vectors = 0;
    int    errs    = 0;
    bit    done    = 1'b0;
    string cur_req = "R9";

    // Reference model state
    int m_cnt  [2];
    bit m_flag [2];

    always #10 clk = ~clk;   // 50 MHz

    adc_cmp_monitor dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .cfg_en(cfg_en), .cfg_chan(cfg_chan), .cfg_ge(cfg_ge),
        .cfg_limit(cfg_limit), .cfg_thresh(cfg_thresh), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .cmp_flag(cmp_flag), .irq(irq)
    );

    task automatic compare();
        logic [1:0] ef;
        logic       ei;
        ef = {m_flag[1], m_flag[0]};
        ei = |(ef & cfg_irq_en);
        vectors++;
        if (cmp_flag !== ef || irq !== ei) begin
            errs++;
            $display("FAIL %s: flags=%b irq=%b expected flags=%b irq=%b",
                     cur_req, cmp_flag, irq, ef, ei);
        end
    endtask

    // Advance one clock with the inputs currently driven, then check
    task automatic step();
        int nc [2];
        bit nf [2];
        for (int u = 0; u < 2; u++) begin
            nc[u] = m_cnt[u];
            nf[u] = m_flag[u];
            if (flag_clr[u]) begin
                nc[u] = 0; nf[u] = 0;
            end else if (!cfg_en[u]) begin
                nc[u] = 0;
            end else if (res_valid && res_chan == cfg_chan[u*3 +: 3]) begin
                int lim, th;
                bit ok;
                lim = int'(cfg_limit[u*12 +: 12]);
                th  = int'(cfg_thresh[u*4 +: 4]);
                ok  = cfg_ge[u] ? (int'(res_data) >= lim) : (int'(res_data) < lim);
                if (!ok)            nc[u] = 0;
                else if (nc[u] >= th) nf[u] = 1;
                else                nc[u] = nc[u] + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            m_cnt[u]  = nc[u];
            m_flag[u] = nf[u];
        end
        res_valid = 1'b0;
        flag_clr  = 2'b00;
        compare();
    endtask

    task automatic res(input logic [2:0] ch, input logic [11:0] d);
        res_valid = 1'b1; res_chan = ch; res_data = d;
        step();
    endtask

    task automatic setup(input int u, input bit en, input logic [2:0] ch, input bit ge,
                         input logic [11:0] lim, input logic [3:0] th, input bit ie);
        cfg_en[u] = en; cfg_chan[u*3 +: 3] = ch; cfg_ge[u] = ge;
        cfg_limit[u*12 +: 12] = lim; cfg_thresh[u*4 +: 4] = th; cfg_irq_en[u] = ie;
    endtask

    task automatic clear(input logic [1:0] m);
        flag_clr = m;
        step();
    endtask

    initial begin
        rst_n = 1'b0; res_valid = 0; res_chan = 0; res_data = 0;
        cfg_en = 0; cfg_chan = 0; cfg_ge = 0; cfg_limit = 0; cfg_thresh = 0;
        cfg_irq_en = 2'b11; flag_clr = 0;
        m_cnt = '{0, 0}; m_flag = '{0, 0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        cur_req = "R9"; compare();
        rst_n = 1'b1;
        step();

        // R4: unit 0 watches channel 2 below 0x100, threshold 2 -> third hit sets
        cur_req = "R4";
        setup(0, 1, 3'd2, 0, 12'h100, 4'd2, 1);
        setup(1, 1, 3'd5, 1, 12'h800, 4'd1, 0);
        res(3'd2, 12'h050); res(3'd2, 12'h0FF); res(3'd2, 12'h000);
        res(3'd2, 12'h010);

        // R1: unit 0 activity left unit 1 untouched; now unit 1 runs
        cur_req = "R1";
        res(3'd5, 12'h900);
        // R5: failing result from watched channel restarts the run
        cur_req = "R5";
        res(3'd5, 12'h100); res(3'd5, 12'h900);
        // R3: equal to the limit is a hit in mode 1
        cur_req = "R3";
        res(3'd5, 12'h800);

        // R6: clear both, then clear in the same cycle as a completing hit
        cur_req = "R6";
        clear(2'b11);
        res(3'd2, 12'h001); res(3'd2, 12'h001);
        flag_clr = 2'b01; res(3'd2, 12'h001);
        res(3'd2, 12'h001);

        // R2: foreign channels and idle strobes do not break or extend a run
        cur_req = "R2";
        res(3'd2, 12'h001);
        res(3'd3, 12'hFFF); res(3'd7, 12'h000);
        res_data = 12'h000; res_chan = 3'd2; step();
        res(3'd2, 12'h001);

        // R10: flag survives later hits, failures and disabling
        cur_req = "R10";
        res(3'd2, 12'hFFF); res(3'd2, 12'h002);
        cfg_en[0] = 1'b0; step();
        cfg_en[0] = 1'b1;

        // R3: mode 0 boundary, equal is not a hit, one below is
        cur_req = "R3";
        clear(2'b01);
        setup(0, 1, 3'd4, 0, 12'h200, 4'd0, 1);
        res(3'd4, 12'h200); res(3'd4, 12'h1FF);

        // R7: disabled unit ignores hits and forgets its run
        cur_req = "R7";
        clear(2'b11);
        setup(1, 0, 3'd6, 1, 12'h400, 4'd1, 1);
        res(3'd6, 12'hFFF); res(3'd6, 12'hFFF);
        cfg_en[1] = 1'b1;
        res(3'd6, 12'hFFF);
        cfg_en[1] = 1'b0; step(); cfg_en[1] = 1'b1;
        res(3'd6, 12'hFFF); res(3'd6, 12'hFFF);

        // R8: interrupt gating follows each enable bit
        cur_req = "R8";
        cfg_irq_en = 2'b00; step();
        cfg_irq_en = 2'b10; step();
        cfg_irq_en = 2'b01; res(3'd4, 12'h000);
        cfg_irq_en = 2'b11; step();

        // Randomised mix of all rules
        cur_req = "R1/R2/R5 random";
        setup(0, 1, 3'd1, 0, 12'h800, 4'd3, 1);
        setup(1, 1, 3'd2, 1, 12'h800, 4'd2, 1);
        for (int i = 0; i < 3000; i++) begin
            res_valid = ($urandom_range(0, 3) != 0);
            res_chan  = 3'($urandom_range(0, 3));
            res_data  = 12'($urandom_range(12'h7F0, 12'h810));
            if ($urandom_range(0, 40) == 0) flag_clr = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 60) == 0) cfg_en = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 200) == 0) cfg_thresh = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 50) == 0) cfg_irq_en = 2'($urandom_range(0, 3));
            step();
        end

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errs++;
            $display("FAIL watchdog (all requirements): run=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

endmodule